// File: doc/BRIEF.md
# Operand Byte Sender

This block takes a pair of 16-bit operands, x and y, from a parallel input with a load strobe. It delivers them as four bytes to a byte-wide transmit register. Each operand is cut into a high byte and a low byte. The bytes always go out in a fixed order, most significant first, with x before y. Before each byte is written, the block looks at the transmitter's empty flag. It raises its one-cycle write strobe only in a cycle where that flag is high.

The fourth write starts a programmable quiet interval. The interval is counted in clock cycles, and no new operand pair is accepted while it runs. The operands are captured when the strobe is seen while the block is idle. After that, changes on the operand inputs and further strobes cannot alter a transfer in progress. A busy output covers the whole span from capture to the end of the quiet interval.

Top module: `opnd_byte_sender`

## Requirements
- R1: While reset is asserted and after its release with no load, busy_o is 0 and tx_wr_o is 0.
- R2: Each operand is split into a high byte (bits 15:8, the value divided by 256) and a low byte (bits 7:0, the remainder).
- R3: The four bytes of a pair leave in the order x high, x low, y high, y low.
- R4: tx_wr_o is high only in cycles where tx_empty_i is high, and each such cycle hands exactly one byte on tx_data_o; while tx_empty_i stays low no byte is written.
- R5: The operands are captured in the cycle ld_i is seen while idle. Operand changes and ld_i pulses during a busy period change neither the bytes sent nor start another transfer.
- R6: After the cycle of the fourth write, busy_o stays high for exactly IDLE_CYC further cycles and then falls.
- R7: busy_o rises in the cycle after the capturing load and stays high until the quiet interval ends.
- R8: A load in the last cycle of the quiet interval is ignored. A load in the first cycle with busy_o low is accepted.
- R9: Asserting reset in the middle of a transfer aborts it. No further byte is written, and busy_o is low afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ld_i | input | 1 | Operand load strobe, honoured only when idle |
| x_i | input | 16 | First operand |
| y_i | input | 16 | Second operand |
| tx_empty_i | input | 1 | Transmit register empty flag |
| tx_wr_o | output | 1 | One-cycle byte write strobe |
| tx_data_o | output | 8 | Byte presented with the write strobe |
| busy_o | output | 1 | High from operand capture until the quiet interval expires |

## Verification
Two of this block's functions can land in the same cycle: the end of the quiet interval and the acceptance of a new load. The bench provokes this by raising ld_i exactly in the last interval cycle, counted from the observed fourth write. It then judges at the ports that busy_o falls and stays low and that no write follows. A second run puts the load one cycle later. There the bench expects busy_o to rise and a complete, correctly ordered byte set to follow. A further pairing is a write in the same cycle as the transmitter's empty flag returning high; the bench's transmitter model uses drain delays of zero to three cycles, and every observed write is checked against the flag.

// File: rtl/sndr_pkg.sv
package sndr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_GAP  = 2'd2
  } snd_state_e;
endpackage

// File: rtl/sndr_ctrl.sv
module sndr_ctrl
  import sndr_pkg::*;
#(
  parameter int NBYTES = 4,
  localparam int IW = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_i,
  input  logic          tx_empty_i,
  input  logic          gap_done_i,
  output snd_state_e    state_o,
  output logic [IW-1:0] idx_o,
  output logic          wr_o,
  output logic          cap_o,
  output logic          gap_start_o
);
  localparam logic [IW-1:0] LAST = IW'(NBYTES - 1);

  snd_state_e    state_q, state_d;
  logic [IW-1:0] idx_q, idx_d;
  logic          wr;

  always_comb begin
    state_d     = state_q;
    idx_d       = idx_q;
    wr          = (state_q == ST_SEND) && tx_empty_i;
    gap_start_o = 1'b0;
    cap_o       = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (ld_i) begin
          cap_o   = 1'b1;
          idx_d   = '0;
          state_d = ST_SEND;
        end
      end
      ST_SEND: begin
        if (wr) begin
          if (idx_q == LAST) begin
            gap_start_o = 1'b1;
            state_d     = ST_GAP;
          end else begin
            idx_d = idx_q + IW'(1);
          end
        end
      end
      ST_GAP: begin
        if (gap_done_i) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
    end
  end

  assign state_o = state_q;
  assign idx_o   = idx_q;
  assign wr_o    = wr;

  // R3: a write inside a transfer moves the byte pointer on by one
  p_idx_advance_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SEND && $past(state_q) == ST_SEND && $past(wr_o))
      |-> idx_q == $past(idx_q) + IW'(1));

  // R4: no byte pointer movement without a write
  p_idx_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SEND && $past(state_q) == ST_SEND && !$past(wr_o))
      |-> $stable(idx_q));
endmodule

// File: rtl/sndr_gap_timer.sv
module sndr_gap_timer #(
  parameter int IDLE_CYC = 1000,
  localparam int CW = $clog2(IDLE_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic active_o,
  output logic done_o
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          act_q, act_d;
  logic          cnt_en;

  assign done_o = act_q && (cnt_q == '0);
  assign cnt_en = start_i || act_q;

  always_comb begin
    cnt_d = cnt_q;
    act_d = act_q;
    if (start_i) begin
      cnt_d = CW'(IDLE_CYC - 1);
      act_d = 1'b1;
    end else if (done_o) begin
      act_d = 1'b0;
    end else if (act_q) begin
      cnt_d = cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
      act_q <= act_d;
    end
  end

  assign active_o = act_q;

  // R6: while running, the interval counter steps down by one per cycle
  p_cnt_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && $past(act_q) && !$past(start_i)) |-> cnt_q == $past(cnt_q) - CW'(1));
endmodule

// File: rtl/sndr_byte_sel.sv
module sndr_byte_sel #(
  parameter int OPW = 16,
  parameter int BW  = 8,
  localparam int BPO = OPW / BW,
  localparam int NB  = 2 * BPO,
  localparam int IW  = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_i,
  input  logic          hold_i,
  input  logic [OPW-1:0] x_i,
  input  logic [OPW-1:0] y_i,
  input  logic [IW-1:0] idx_i,
  output logic [BW-1:0] byte_o
);
  logic [OPW-1:0] opx_q, opy_q;
  logic [BW-1:0]  lane [NB];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opx_q <= '0;
      opy_q <= '0;
    end else if (cap_i) begin
      opx_q <= x_i;
      opy_q <= y_i;
    end
  end

  for (genvar k = 0; k < BPO; k++) begin : g_lane
    assign lane[k]       = opx_q[OPW-1-k*BW -: BW];
    assign lane[BPO + k] = opy_q[OPW-1-k*BW -: BW];
  end

  assign byte_o = lane[idx_i];

  // R5: captured operands do not move during a busy period
  p_latch_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_i && $past(hold_i)) |-> ($stable(opx_q) && $stable(opy_q)));
endmodule

// File: rtl/opnd_byte_sender.sv
module opnd_byte_sender
  import sndr_pkg::*;
#(
  parameter int OPW      = 16,
  parameter int BW       = 8,
  parameter int IDLE_CYC = 1000,
  localparam int NB      = 2 * (OPW / BW),
  localparam int IW      = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_i,
  input  logic [OPW-1:0] x_i,
  input  logic [OPW-1:0] y_i,
  input  logic          tx_empty_i,
  output logic          tx_wr_o,
  output logic [BW-1:0] tx_data_o,
  output logic          busy_o
);
  logic          rs_q1, rs_q2;
  logic          rst_in_n;
  snd_state_e    state;
  logic [IW-1:0] idx;
  logic          cap, gap_start, gap_done, gap_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q1 <= 1'b0;
      rs_q2 <= 1'b0;
    end else begin
      rs_q1 <= 1'b1;
      rs_q2 <= rs_q1;
    end
  end
  assign rst_in_n = rs_q2;

  sndr_ctrl #(.NBYTES(NB)) ctrl_i (
    .clk        (clk),
    .rst_n      (rst_in_n),
    .ld_i       (ld_i),
    .tx_empty_i (tx_empty_i),
    .gap_done_i (gap_done),
    .state_o    (state),
    .idx_o      (idx),
    .wr_o       (tx_wr_o),
    .cap_o      (cap),
    .gap_start_o(gap_start)
  );

  sndr_gap_timer #(.IDLE_CYC(IDLE_CYC)) gap_i (
    .clk     (clk),
    .rst_n   (rst_in_n),
    .start_i (gap_start),
    .active_o(gap_active),
    .done_o  (gap_done)
  );

  sndr_byte_sel #(.OPW(OPW), .BW(BW)) sel_i (
    .clk   (clk),
    .rst_n (rst_in_n),
    .cap_i (cap),
    .hold_i(busy_o),
    .x_i   (x_i),
    .y_i   (y_i),
    .idx_i (idx),
    .byte_o(tx_data_o)
  );

  assign busy_o = (state != ST_IDLE);

  // R4: a byte is written only while a transfer is under way
  p_wr_while_busy_r4: assert property (@(posedge clk) disable iff (!rst_in_n)
    tx_wr_o |-> busy_o);

  // R6: the quiet interval starts right after a write
  p_gap_after_write_r6: assert property (@(posedge clk) disable iff (!rst_in_n)
    $rose(gap_active) |-> $past(tx_wr_o));

  // R7: busy only drops when the interval timer has just finished
  p_busy_fall_r7: assert property (@(posedge clk) disable iff (!rst_in_n)
    $fell(busy_o) |-> ($past(gap_active) && !gap_active));
endmodule

// File: tb/opnd_byte_sender_tb_top.sv
module opnd_byte_sender_tb_top;
  localparam int GAP = 6;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        ld = 1'b0;
  logic [15:0] xin = '0, yin = '0;
  logic        txe = 1'b1;
  wire         wr;
  wire  [7:0]  dat;
  wire         busy;

  int n_chk = 0, n_fail = 0;
  int cyc = 0, wr_cnt = 0, last_wr_cyc = 0, fall_cyc = 0, viol = 0;
  int drain = 0, dcnt = 0;
  logic hold_lo = 1'b0, pend = 1'b0, prev_busy = 1'b0;
  logic [7:0] got[$];

  opnd_byte_sender #(.IDLE_CYC(GAP)) dut_i (
    .clk(clk), .rst_n(rst_n), .ld_i(ld), .x_i(xin), .y_i(yin),
    .tx_empty_i(txe), .tx_wr_o(wr), .tx_data_o(dat), .busy_o(busy)
  );

  // transmitter model and port monitor, all activity between clock edges
  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      pend = 1'b0; dcnt = 0; txe = 1'b1;
    end else begin
      if (pend && drain > 0) dcnt = drain;
      else if (dcnt > 0) dcnt--;
      pend = 1'b0;
      txe = !hold_lo && (dcnt == 0);
    end
    #1;
    if (wr) begin
      if (!txe || !busy) viol++;
      got.push_back(dat);
      wr_cnt++;
      last_wr_cyc = cyc;
      pend = 1'b1;
    end
    if (prev_busy && !busy) fall_cyc = cyc;
    prev_busy = busy;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic send(input logic [15:0] x, input logic [15:0] y);
    @(negedge clk); ld = 1'b1; xin = x; yin = y;
    @(negedge clk); ld = 1'b0;
    #2 chk(busy == 1'b1, "R7", "busy after load", int'(busy), 1);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 500; i++) begin
      @(negedge clk); #2;
      if (!busy) break;
    end
  endtask

  task automatic check_bytes(input int base, input logic [15:0] x, input logic [15:0] y);
    chk(got.size() == base + 4, "R4", "byte count", got.size() - base, 4);
    if (got.size() >= base + 4) begin
      chk(got[base]   == x[15:8], "R2", "x high", got[base],   x[15:8]);
      chk(got[base+1] == x[7:0],  "R3", "x low",  got[base+1], x[7:0]);
      chk(got[base+2] == y[15:8], "R3", "y high", got[base+2], y[15:8]);
      chk(got[base+3] == y[7:0],  "R2", "y low",  got[base+3], y[7:0]);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; ld = 1'b0;
    repeat (3) @(negedge clk);
    #2 chk(busy == 1'b0 && wr == 1'b0, "R1", "outputs in reset", {busy, wr}, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #2 chk(busy == 1'b0, "R1", "busy after release", busy, 0);
    chk(wr_cnt == 0, "R1", "writes after release", wr_cnt, 0);
  endtask

  task automatic t_basic(input logic [15:0] x, input logic [15:0] y, input int d);
    int base;
    drain = d; base = got.size();
    send(x, y);
    wait_idle();
    check_bytes(base, x, y);
    chk(fall_cyc - last_wr_cyc - 1 == GAP, "R6", "quiet interval",
        fall_cyc - last_wr_cyc - 1, GAP);
  endtask

  task automatic t_hold();
    int base, w0;
    drain = 0; base = got.size(); w0 = wr_cnt;
    hold_lo = 1'b1;
    send(16'h3C5A, 16'h9817);
    repeat (10) @(negedge clk);
    #2 chk(wr_cnt == w0, "R4", "no write while full", wr_cnt - w0, 0);
    chk(busy == 1'b1, "R7", "busy while waiting", busy, 1);
    hold_lo = 1'b0;
    wait_idle();
    check_bytes(base, 16'h3C5A, 16'h9817);
  endtask

  task automatic t_ignore();
    int base;
    drain = 2; base = got.size();
    send(16'h1234, 16'h5678);
    @(negedge clk); ld = 1'b1; xin = 16'hAAAA; yin = 16'hBBBB;
    repeat (3) @(negedge clk);
    ld = 1'b0; xin = 16'hCCCC;
    wait_idle();
    check_bytes(base, 16'h1234, 16'h5678);
    repeat (10) @(negedge clk);
    #2 chk(got.size() == base + 4, "R5", "no extra transfer", got.size() - base, 4);
    chk(busy == 1'b0, "R5", "stays idle", busy, 0);
  endtask

  task automatic t_collide();
    int base;
    drain = 0; base = got.size();
    send(16'h0F0F, 16'hF0F0);
    for (int i = 0; i < 100 && wr_cnt < base + 4; i++) begin @(negedge clk); #2; end
    repeat (GAP) @(negedge clk);
    ld = 1'b1; xin = 16'h4444; yin = 16'h5555;
    @(negedge clk); ld = 1'b0;
    #2 chk(busy == 1'b0, "R8", "load on last quiet cycle ignored", busy, 0);
    repeat (5) @(negedge clk);
    #2 chk(busy == 1'b0 && got.size() == base + 4, "R8", "no transfer started",
           got.size() - base, 4);
    base = got.size();
    send(16'h2468, 16'h1357);
    for (int i = 0; i < 100 && wr_cnt < base + 4; i++) begin @(negedge clk); #2; end
    repeat (GAP + 1) @(negedge clk);
    ld = 1'b1; xin = 16'h8001; yin = 16'h00FE;
    @(negedge clk); ld = 1'b0;
    #2 chk(busy == 1'b1, "R8", "load on first idle cycle accepted", busy, 1);
    wait_idle();
    check_bytes(base + 4, 16'h8001, 16'h00FE);
  endtask

  task automatic t_abort();
    int base;
    drain = 3; base = wr_cnt;
    send(16'hDEAD, 16'hBEEF);
    for (int i = 0; i < 100 && wr_cnt < base + 2; i++) begin @(negedge clk); #2; end
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    #2 chk(busy == 1'b0 && wr == 1'b0, "R9", "aborted by reset", {busy, wr}, 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    #2 chk(wr_cnt == base + 2, "R9", "no write after abort", wr_cnt - base, 2);
    chk(busy == 1'b0, "R9", "idle after abort", busy, 0);
    t_basic(16'h0102, 16'h0304, 0);
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_basic(16'hA5C3, 16'h1E0F, 0);
    t_basic(16'h00FF, 16'hFF00, 3);
    t_basic(16'hFFFF, 16'h0001, 1);
    t_hold();
    t_ignore();
    t_collide();
    t_abort();
    chk(viol == 0, "R4", "writes only when empty and busy", viol, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule